// File: doc/BRIEF.md
# Banked Private Interrupt Register Bank

This block holds the software-visible state of 32 interrupts that belong to one processor core. Interrupts 0 to 15 are raised by software requests; interrupts 16 to 31 come from peripheral input lines. A small memory-mapped port carries word and byte accesses, each with a secure/non-secure attribute. A chip-wide input turns the security model off. Behind the port sit several per-interrupt bitmaps: group, enable, pending and active. Each of the last three has separate set and clear addresses. The block also holds one 8-bit priority per interrupt, the edge/level selection for the peripheral interrupts, a group-modifier bitmap, a 2-bit non-secure access field per software interrupt, and a sleep handshake register.

Every access is filtered per interrupt. With security enabled, a non-secure access sees and changes only interrupts whose group bit is 1. A non-secure access also sees priorities in a halved, shifted form. Peripheral lines are sampled each cycle: a rising edge latches a pending bit when the interrupt is edge-triggered, and a level-triggered line shows up directly in the pending read. Software interrupt requests arrive on a separate port and are checked against group and security before they set a pending bit.

Each access gets a response one cycle later. Unknown offsets read as zero, ignore writes and raise an error pulse.

Top module: `pirq_bank`

## Requirements
- R1: After reset every bitmap, priority, configuration, access field and the sleep register read as zero.
- R2: While `sec_disable` is 0, a non-secure access reads bits only for interrupts whose group bit is 1; other bits read 0 and ignore writes. The group register (offset 0x04) reads 0 and ignores writes for such an access. With `sec_disable` 1 every bit is visible.
- R3: The enable (0x08 set, 0x0C clear), pending (0x10 set, 0x14 clear) and active (0x18 set, 0x1C clear) pairs work the same way. A set write ORs the permitted bits in, a clear write removes them, and both addresses of a pair read the same masked bitmap.
- R4: A pending read returns the pending latch ORed with the sampled line of every peripheral interrupt configured as level-triggered.
- R5: A non-secure priority read (security enabled) returns the stored byte shifted left one place, truncated to 8 bits. A non-secure write stores 0x80 ORed with the data shifted right one place. Priorities of group-0 interrupts are hidden from and protected against such accesses.
- R6: Priorities sit at 0x40..0x5F, one byte per interrupt. A word access covers four interrupts, with the lowest-numbered in bits [7:0]. A byte access at any offset in that window uses bits [7:0].
- R7: Register 0x24 holds the edge selection of interrupt 16+k in bit 2k+1 (1 = edge); its even bits read 0. Register 0x20 reads 0 and ignores writes.
- R8: A rising sampled edge on a peripheral line sets its pending latch only when that interrupt is edge-triggered. A line held high causes no new latch after it is cleared.
- R9: The group-modifier (0x28) and access-field (0x2C, field of interrupt n in bits [2n+1:2n]) registers read 0 and ignore writes when `sec_disable` is 1 or the access is non-secure.
- R10: A software request names a group: 0 = group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = dropped. With security enabled, the target's class comes from its bits: group bit 1 means non-secure group 1; group bit 0 with modifier 1 means secure group 1; both 0 means group 0. A group-1 request to a group-0 target counts as group 0, and any other mismatch is dropped. With `sec_disable` 1, only a group-0 request to a group-bit-1 target is dropped. An accepted request sets the target's pending bit and pulses `sgi_ack` one cycle later; a dropped one pulses `sgi_nack`.
- R11: With security enabled, a non-secure request that matches a group-0 target needs an access field of at least 1. One that matches a secure group-1 target needs at least 2. Otherwise the request is dropped.
- R12: The sleep register (0x00) keeps only bit 0 of a write; bit 1 reads back equal to bit 0.
- R13: A byte access outside the priority window, a misaligned word access, or any unlisted offset changes no state. It returns zero data and pulses `bad_access` together with its response.
- R14: Every request gives exactly one `rsp_valid` pulse on the following cycle; write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_disable | input | 1 | Chip-wide security-off control |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_secure | input | 1 | 1 = secure access |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data (byte data in bits [7:0]) |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data |
| bad_access | output | 1 | Pulse with the response of an unmapped access |
| ppi_level | input | NUM_PPI | Peripheral interrupt lines (bit k is interrupt 16+k) |
| sgi_valid | input | 1 | Software interrupt request strobe |
| sgi_id | input | log2(NUM_SGI) | Target software interrupt |
| sgi_group | input | 2 | Requested group (R10 encoding) |
| sgi_secure | input | 1 | Requester is secure |
| sgi_ack | output | 1 | Request accepted pulse |
| sgi_nack | output | 1 | Request dropped pulse |

## Verification
The bench checks that a non-secure access with mixed group bits reaches only the group-1 bits. A design that skipped this mask would let non-secure software enable or clear secure interrupts. It also drives the priority shift both ways and the byte-lane order of word priority accesses; a swapped lane or a missing 0x80 would show up as a wrong byte on read-back. Peripheral lines are toggled and held to tell an edge latch from a level view, which catches a design that latches level interrupts or re-latches a held line. Software requests are sent for every class against group/access-field mismatches, where a wrong comparison would silently pend or drop the interrupt.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int DATA_W = 32;

  // byte offsets of the register window
  localparam int OFS_SLEEP  = 'h00;
  localparam int OFS_GROUP  = 'h04;
  localparam int OFS_EN_S   = 'h08;
  localparam int OFS_EN_C   = 'h0C;
  localparam int OFS_PD_S   = 'h10;
  localparam int OFS_PD_C   = 'h14;
  localparam int OFS_AC_S   = 'h18;
  localparam int OFS_AC_C   = 'h1C;
  localparam int OFS_CFG_LO = 'h20;
  localparam int OFS_CFG_HI = 'h24;
  localparam int OFS_GMOD   = 'h28;
  localparam int OFS_NSACC  = 'h2C;
  localparam int OFS_PRIO   = 'h40;

  typedef enum logic [3:0] {
    RG_NONE, RG_SLEEP, RG_GROUP, RG_EN_S, RG_EN_C, RG_PD_S, RG_PD_C,
    RG_AC_S, RG_AC_C, RG_CFG_LO, RG_CFG_HI, RG_GMOD, RG_NSACC, RG_PRIO
  } reg_sel_e;

  localparam logic [1:0] SG_G0   = 2'd0;
  localparam logic [1:0] SG_G1S  = 2'd1;
  localparam logic [1:0] SG_G1NS = 2'd2;

endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
  import pirq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_byte,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);

  logic in_prio;
  int   off;

  always_comb begin
    off     = int'(addr);
    in_prio = (off >= OFS_PRIO) && (off < OFS_PRIO + NUM_IRQ);
    idx     = IDX_W'(off - OFS_PRIO);
    sel     = RG_NONE;
    if (in_prio) begin
      if (is_byte || addr[1:0] == 2'b00) sel = RG_PRIO;
    end else if (!is_byte && addr[1:0] == 2'b00) begin
      case (off)
        OFS_SLEEP:  sel = RG_SLEEP;
        OFS_GROUP:  sel = RG_GROUP;
        OFS_EN_S:   sel = RG_EN_S;
        OFS_EN_C:   sel = RG_EN_C;
        OFS_PD_S:   sel = RG_PD_S;
        OFS_PD_C:   sel = RG_PD_C;
        OFS_AC_S:   sel = RG_AC_S;
        OFS_AC_C:   sel = RG_AC_C;
        OFS_CFG_LO: sel = RG_CFG_LO;
        OFS_CFG_HI: sel = RG_CFG_HI;
        OFS_GMOD:   sel = RG_GMOD;
        OFS_NSACC:  sel = RG_NSACC;
        default:    sel = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/pirq_prio.sv
module pirq_prio #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int LANES  = 4,
  localparam int LANE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic                   is_byte,
  input  logic [IDX_W-1:0]       idx,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                   ns_view,
  input  logic [NUM_IRQ-1:0]     grp_vec,
  output logic [LANES*LANE_W-1:0] rdata
);

  logic [LANE_W-1:0] mem [NUM_IRQ];

  logic [IDX_W-1:0]  lane_irq [LANES];
  logic [LANES-1:0]  lane_on;
  logic [LANE_W-1:0] lane_wval [LANES];
  logic [LANE_W-1:0] lane_rval [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] din;
    logic              ok;
    assign lane_irq[l] = idx + IDX_W'(l);
    assign din         = is_byte ? wdata[LANE_W-1:0] : wdata[l*LANE_W +: LANE_W];
    // group-0 entries are invisible to a restricted access
    assign ok          = !ns_view || grp_vec[lane_irq[l]];
    assign lane_on[l]  = ok && (!is_byte || l == 0);
    assign lane_wval[l] = ns_view ? {1'b1, din[LANE_W-1:1]} : din;
    assign lane_rval[l] = !ok ? '0 :
                          ns_view ? {mem[lane_irq[l]][LANE_W-2:0], 1'b0} :
                          mem[lane_irq[l]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IRQ; i++) mem[i] <= '0;
    end else if (wr) begin
      for (int l = 0; l < LANES; l++)
        if (lane_on[l]) mem[lane_irq[l]] <= lane_wval[l];
    end
  end

  always_comb begin
    if (is_byte) begin
      rdata = '0;
      rdata[LANE_W-1:0] = lane_rval[0];
    end else begin
      for (int l = 0; l < LANES; l++) rdata[l*LANE_W +: LANE_W] = lane_rval[l];
    end
  end

endmodule

// File: rtl/pirq_sgi_gate.sv
module pirq_sgi_gate
  import pirq_pkg::*;
(
  input  logic       sec_disable,
  input  logic       req_secure,
  input  logic [1:0] req_grp,
  input  logic       grp_bit,
  input  logic       gmod_bit,
  input  logic [1:0] acc,
  output logic       ok
);

  logic [1:0] cls;
  logic [1:0] eff;

  always_comb begin
    cls = grp_bit ? SG_G1NS : (gmod_bit ? SG_G1S : SG_G0);
    eff = (cls == SG_G0 && req_grp != SG_G0) ? SG_G0 : req_grp;
    ok  = 1'b0;
    if (req_grp == 2'd3) begin
      ok = 1'b0;
    end else if (sec_disable) begin
      ok = (req_grp == SG_G0) ? !grp_bit : 1'b1;
    end else if (eff == cls) begin
      if (req_secure)          ok = 1'b1;
      else if (cls == SG_G0)   ok = (acc >= 2'd1);
      else if (cls == SG_G1S)  ok = (acc >= 2'd2);
      else                     ok = 1'b1;
    end
  end

endmodule

// File: rtl/pirq_bank.sv
module pirq_bank
  import pirq_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  parameter int ADDR_W  = 8,
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
  localparam int SGI_W   = $clog2(NUM_SGI),
  localparam int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_disable,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_byte,
  input  logic               req_secure,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               bad_access,
  input  logic [NUM_PPI-1:0] ppi_level,
  input  logic               sgi_valid,
  input  logic [SGI_W-1:0]   sgi_id,
  input  logic [1:0]         sgi_group,
  input  logic               sgi_secure,
  output logic               sgi_ack,
  output logic               sgi_nack
);

  // odd-bit packing of the edge selection
  function automatic logic [2*NUM_PPI-1:0] spread_odd(input logic [NUM_PPI-1:0] v);
    logic [2*NUM_PPI-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_PPI; k++) r[2*k+1] = v[k];
    return r;
  endfunction

  function automatic logic [NUM_PPI-1:0] gather_odd(input logic [2*NUM_PPI-1:0] v);
    logic [NUM_PPI-1:0] r;
    for (int k = 0; k < NUM_PPI; k++) r[k] = v[2*k+1];
    return r;
  endfunction

  logic [NUM_IRQ-1:0]   grp_q, en_q, pd_q, ac_q, gmod_q;
  logic [2*NUM_SGI-1:0] nsacc_q;
  logic [NUM_PPI-1:0]   edge_q, ppi_s, ppi_p;
  logic                 sleep_q;

  reg_sel_e           sel;
  logic [IDX_W-1:0]   prio_idx;
  logic [DATA_W-1:0]  prio_rd;
  logic               ns_restr, sec_only_ok, wr_go, sgi_ok;
  logic [NUM_IRQ-1:0] vis, wmask, lvl_vec, edge_vec, pend_view;
  logic [NUM_IRQ-1:0] pd_set, pd_clr, rise_vec, sgi_vec;
  logic [NUM_PPI-1:0] edge_m;
  logic [DATA_W-1:0]  rd_val;

  pirq_decode #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_dec (
    .addr(req_addr), .is_byte(req_byte), .sel(sel), .idx(prio_idx)
  );

  assign ns_restr    = !req_secure && !sec_disable;
  assign sec_only_ok = req_secure && !sec_disable;
  assign vis         = ns_restr ? grp_q : '1;
  assign wmask       = req_wdata & vis;
  assign wr_go       = req_valid && req_write;

  pirq_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .clk(clk), .rst(rst), .wr(wr_go && sel == RG_PRIO), .is_byte(req_byte),
    .idx(prio_idx), .wdata(req_wdata), .ns_view(ns_restr), .grp_vec(grp_q),
    .rdata(prio_rd)
  );

  pirq_sgi_gate u_gate (
    .sec_disable(sec_disable), .req_secure(sgi_secure), .req_grp(sgi_group),
    .grp_bit(grp_q[sgi_id]), .gmod_bit(gmod_q[sgi_id]),
    .acc(nsacc_q[2*sgi_id +: 2]), .ok(sgi_ok)
  );

  assign lvl_vec   = {ppi_s, {NUM_SGI{1'b0}}};
  assign edge_vec  = {edge_q, {NUM_SGI{1'b0}}};
  assign pend_view = pd_q | (~edge_vec & lvl_vec);

  for (genvar k = 0; k < NUM_PPI; k++) begin : g_edge
    assign rise_vec[NUM_SGI+k] = edge_q[k] && ppi_s[k] && !ppi_p[k];
  end
  assign rise_vec[NUM_SGI-1:0] = '0;

  assign sgi_vec = (sgi_valid && sgi_ok) ? (NUM_IRQ'(1) << sgi_id) : '0;
  assign pd_set  = (wr_go && sel == RG_PD_S) ? wmask : '0;
  assign pd_clr  = (wr_go && sel == RG_PD_C) ? wmask : '0;
  assign edge_m  = vis[NUM_IRQ-1:NUM_SGI];

  always_comb begin
    case (sel)
      RG_SLEEP:         rd_val = {{(DATA_W-2){1'b0}}, sleep_q, sleep_q};
      RG_GROUP:         rd_val = ns_restr ? '0 : grp_q;
      RG_EN_S, RG_EN_C: rd_val = en_q & vis;
      RG_PD_S, RG_PD_C: rd_val = pend_view & vis;
      RG_AC_S, RG_AC_C: rd_val = ac_q & vis;
      RG_CFG_LO:        rd_val = '0;
      RG_CFG_HI:        rd_val = spread_odd(edge_q & edge_m);
      RG_GMOD:          rd_val = sec_only_ok ? gmod_q : '0;
      RG_NSACC:         rd_val = sec_only_ok ? nsacc_q : '0;
      RG_PRIO:          rd_val = prio_rd;
      default:          rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= '0; en_q <= '0; pd_q <= '0; ac_q <= '0; gmod_q <= '0;
      nsacc_q <= '0; edge_q <= '0; ppi_s <= '0; ppi_p <= '0; sleep_q <= 1'b0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; bad_access <= 1'b0;
      sgi_ack <= 1'b0; sgi_nack <= 1'b0;
    end else begin
      ppi_s <= ppi_level;
      ppi_p <= ppi_s;
      pd_q  <= (pd_q | pd_set | rise_vec | sgi_vec) & ~pd_clr;
      if (wr_go) begin
        case (sel)
          RG_SLEEP:  sleep_q <= req_wdata[0];
          RG_GROUP:  if (!ns_restr) grp_q <= req_wdata;
          RG_EN_S:   en_q <= en_q | wmask;
          RG_EN_C:   en_q <= en_q & ~wmask;
          RG_AC_S:   ac_q <= ac_q | wmask;
          RG_AC_C:   ac_q <= ac_q & ~wmask;
          RG_CFG_HI: edge_q <= (edge_q & ~edge_m) | (gather_odd(req_wdata) & edge_m);
          RG_GMOD:   if (sec_only_ok) gmod_q <= req_wdata;
          RG_NSACC:  if (sec_only_ok) nsacc_q <= req_wdata;
          default:   ;
        endcase
      end
      rsp_valid  <= req_valid;
      rsp_rdata  <= (req_valid && !req_write) ? rd_val : '0;
      bad_access <= req_valid && sel == RG_NONE;
      sgi_ack    <= sgi_valid && sgi_ok;
      sgi_nack   <= sgi_valid && !sgi_ok;
    end
  end

endmodule

// File: rtl/pirq_bank_chk.sv
module pirq_bank_chk
  import pirq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_disable,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_byte,
  input logic              req_secure,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bad_access,
  input logic              sgi_valid,
  input logic              sgi_ack,
  input logic              sgi_nack
);

  logic word_rd;
  assign word_rd = req_valid && !req_write && !req_byte;

  p_rsp_follows_req_r14: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_stray_rsp_r14: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_write_rsp_zero_r14: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> rsp_rdata == '0);

  p_bad_reads_zero_r13: assert property (@(posedge clk) disable iff (rst)
    bad_access |-> (rsp_valid && rsp_rdata == '0));

  p_sgi_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    sgi_valid |=> (sgi_ack ^ sgi_nack));

  p_sgi_no_stray_r10: assert property (@(posedge clk) disable iff (rst)
    !sgi_valid |=> !(sgi_ack || sgi_nack));

  p_sleep_mirror_r12: assert property (@(posedge clk) disable iff (rst)
    (word_rd && int'(req_addr) == OFS_SLEEP) |=>
      (rsp_rdata[1] == rsp_rdata[0] && rsp_rdata[DATA_W-1:2] == '0));

  p_secure_regs_raz_r9: assert property (@(posedge clk) disable iff (rst)
    (word_rd && (int'(req_addr) == OFS_GMOD || int'(req_addr) == OFS_NSACC) &&
     (!req_secure || sec_disable)) |=> rsp_rdata == '0);

endmodule

bind pirq_bank pirq_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sec_disable(sec_disable), .req_valid(req_valid),
  .req_write(req_write), .req_byte(req_byte), .req_secure(req_secure),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .bad_access(bad_access), .sgi_valid(sgi_valid), .sgi_ack(sgi_ack),
  .sgi_nack(sgi_nack)
);

// File: tb/pirq_bank_bench.sv
module pirq_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_disable = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_secure = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, bad_access;
  logic [31:0] rsp_rdata;
  logic [15:0] ppi_level = '0;
  logic        sgi_valid = 1'b0, sgi_secure = 1'b0;
  logic [3:0]  sgi_id = '0;
  logic [1:0]  sgi_group = '0;
  logic        sgi_ack, sgi_nack;

  int checks = 0;
  int fails  = 0;

  logic [31:0] q_data[$];
  logic        q_bad[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  pirq_bank u_pirq_bank (
    .clk(clk), .rst(rst), .sec_disable(sec_disable), .req_valid(req_valid),
    .req_write(req_write), .req_byte(req_byte), .req_secure(req_secure),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bad_access(bad_access), .ppi_level(ppi_level),
    .sgi_valid(sgi_valid), .sgi_id(sgi_id), .sgi_group(sgi_group),
    .sgi_secure(sgi_secure), .sgi_ack(sgi_ack), .sgi_nack(sgi_nack)
  );

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (q_data.size() == 0) begin
        fails++;
        $display("FAIL R14 unexpected response got %h expected none", rsp_rdata);
      end else begin
        logic [31:0] ed;
        logic        eb;
        string       et;
        ed = q_data.pop_front();
        eb = q_bad.pop_front();
        et = q_tag.pop_front();
        if (rsp_rdata !== ed || bad_access !== eb) begin
          fails++;
          $display("FAIL %s got %h/bad=%0b expected %h/bad=%0b", et, rsp_rdata, bad_access, ed, eb);
        end
      end
    end
  end

  task automatic acc(input bit wr, input bit byt, input bit sec, input logic [7:0] a,
                     input logic [31:0] wd, input logic [31:0] exp, input bit ebad,
                     input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = byt; req_secure = sec;
    req_addr = a; req_wdata = wd;
    q_data.push_back(wr ? 32'h0 : exp);
    q_bad.push_back(ebad);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr32(input bit sec, input logic [7:0] a, input logic [31:0] wd, input string tag);
    acc(1'b1, 1'b0, sec, a, wd, 32'h0, 1'b0, tag);
  endtask

  task automatic rd32(input bit sec, input logic [7:0] a, input logic [31:0] exp, input string tag);
    acc(1'b0, 1'b0, sec, a, 32'h0, exp, 1'b0, tag);
  endtask

  task automatic sgi(input logic [3:0] id, input logic [1:0] g, input bit sec,
                     input bit exp_ok, input string tag);
    @(negedge clk);
    sgi_valid = 1'b1; sgi_id = id; sgi_group = g; sgi_secure = sec;
    @(negedge clk);
    sgi_valid = 1'b0;
    checks++;
    if (sgi_ack !== exp_ok || sgi_nack !== !exp_ok) begin
      fails++;
      $display("FAIL %s got ack=%0b nack=%0b expected ack=%0b", tag, sgi_ack, sgi_nack, exp_ok);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    rd32(1, 8'h04, 32'h0, "R1 group");
    rd32(1, 8'h08, 32'h0, "R1 enable");
    rd32(1, 8'h10, 32'h0, "R1 pending");
    rd32(1, 8'h40, 32'h0, "R1 priority");
    rd32(1, 8'h00, 32'h0, "R1 sleep");

    // R2 group register visibility
    wr32(1, 8'h04, 32'hFFFF_00F0, "R2 write group");
    rd32(1, 8'h04, 32'hFFFF_00F0, "R2 secure group read");
    rd32(0, 8'h04, 32'h0, "R2 ns group read");
    wr32(0, 8'h04, 32'h0, "R2 ns group write");
    rd32(1, 8'h04, 32'hFFFF_00F0, "R2 group unchanged");

    // R3 enable aliases with masking
    wr32(1, 8'h08, 32'h3, "R3 secure set");
    wr32(0, 8'h08, 32'hFFFF_FFFF, "R3 ns set");
    rd32(1, 8'h0C, 32'hFFFF_00F3, "R3 clear alias read");
    rd32(0, 8'h08, 32'hFFFF_00F0, "R2 ns enable view");
    wr32(0, 8'h0C, 32'h0000_00FF, "R3 ns clear");
    rd32(1, 8'h08, 32'hFFFF_0003, "R3 after ns clear");
    wr32(1, 8'h18, 32'h8000_0001, "R3 active set");
    rd32(1, 8'h1C, 32'h8000_0001, "R3 active read");
    wr32(1, 8'h1C, 32'h1, "R3 active clear");
    rd32(1, 8'h18, 32'h8000_0000, "R3 active after clear");

    // R5 R6 priorities
    wr32(1, 8'h44, 32'h4433_2211, "R6 word write");
    acc(0, 1, 1, 8'h46, 32'h0, 32'h33, 0, "R6 byte lane order");
    rd32(0, 8'h44, 32'h8866_4422, "R5 ns shifted view");
    acc(1, 1, 0, 8'h45, 32'h40, 32'h0, 0, "R5 ns byte write");
    acc(0, 1, 1, 8'h45, 32'h0, 32'hA0, 0, "R5 stored value");
    acc(0, 1, 0, 8'h45, 32'h0, 32'h40, 0, "R5 ns byte read");
    wr32(1, 8'h40, 32'hDDCC_BBAA, "R6 word write group0");
    rd32(0, 8'h40, 32'h0, "R5 group0 hidden");
    acc(1, 1, 0, 8'h40, 32'h12, 32'h0, 0, "R5 ns write to group0");
    rd32(1, 8'h40, 32'hDDCC_BBAA, "R5 group0 protected");

    // R7 edge configuration
    wr32(1, 8'h24, 32'h0000_000F, "R7 cfg write");
    rd32(1, 8'h24, 32'h0000_000A, "R7 odd bits only");
    wr32(1, 8'h20, 32'hFFFF_FFFF, "R7 low cfg write");
    rd32(1, 8'h20, 32'h0, "R7 low cfg zero");

    // R4 R8 peripheral lines: irq16,17 edge, irq18 level
    @(negedge clk) ppi_level = 16'h0005;
    idle(3);
    rd32(1, 8'h10, 32'h0005_0000, "R4 latch plus level");
    @(negedge clk) ppi_level = 16'h0000;
    idle(3);
    rd32(1, 8'h10, 32'h0001_0000, "R8 latch kept level gone");
    wr32(1, 8'h14, 32'h0001_0000, "R3 pending clear");
    rd32(1, 8'h10, 32'h0, "R3 pending cleared");
    @(negedge clk) ppi_level = 16'h0001;
    idle(3);
    rd32(1, 8'h14, 32'h0001_0000, "R8 new rising edge");
    wr32(1, 8'h14, 32'h0001_0000, "R8 clear while high");
    idle(3);
    rd32(1, 8'h10, 32'h0, "R8 held level no relatch");
    @(negedge clk) ppi_level = 16'h0000;
    idle(3);

    // R9 secure-only registers
    wr32(1, 8'h28, 32'h2, "R9 gmod write");
    rd32(1, 8'h28, 32'h2, "R9 gmod read");
    rd32(0, 8'h28, 32'h0, "R9 gmod ns read");
    wr32(0, 8'h28, 32'hFFFF_FFFF, "R9 gmod ns write");
    rd32(1, 8'h28, 32'h2, "R9 gmod unchanged");
    wr32(1, 8'h2C, 32'h9, "R9 access field write");
    rd32(1, 8'h2C, 32'h9, "R9 access field read");
    rd32(0, 8'h2C, 32'h0, "R9 access field ns read");

    // R10 R11 software requests; classes: 0,2,3 G0, 1 G1S, 4..7 G1NS, 8..15 G0
    wr32(1, 8'h14, 32'hFFFF_FFFF, "R3 clear all pending");
    sgi(4'd2, 2'd0, 1, 1, "R10 secure G0 to G0");
    sgi(4'd5, 2'd1, 1, 0, "R10 G1S to G1NS dropped");
    sgi(4'd5, 2'd2, 0, 1, "R10 ns G1NS to G1NS");
    sgi(4'd3, 2'd1, 1, 1, "R10 G1 to G0 treated as G0");
    sgi(4'd2, 2'd0, 0, 0, "R11 ns G0 access 0");
    sgi(4'd0, 2'd0, 0, 1, "R11 ns G0 access 1");
    sgi(4'd1, 2'd1, 0, 1, "R11 ns G1S access 2");
    sgi(4'd1, 2'd2, 0, 0, "R10 G1NS to G1S dropped");
    sgi(4'd8, 2'd1, 0, 0, "R11 ns treated G0 access 0");
    sgi(4'd4, 2'd0, 1, 0, "R10 G0 to G1NS dropped");
    sgi(4'd6, 2'd3, 1, 0, "R10 reserved group dropped");
    rd32(1, 8'h10, 32'h0000_002F, "R10 pending from requests");

    // security disabled
    @(negedge clk) sec_disable = 1'b1;
    rd32(1, 8'h28, 32'h0, "R9 gmod hidden when disabled");
    sgi(4'd4, 2'd0, 1, 0, "R10 disabled G0 to group1");
    sgi(4'd6, 2'd2, 1, 1, "R10 disabled G1 to group1");
    sgi(4'd9, 2'd0, 0, 1, "R11 disabled no access check");
    rd32(0, 8'h04, 32'hFFFF_00F0, "R2 disabled ns sees group");
    rd32(0, 8'h10, 32'h0000_026F, "R2 disabled ns sees pending");
    @(negedge clk) sec_disable = 1'b0;

    // R12 sleep
    wr32(1, 8'h00, 32'hFFFF_FFFF, "R12 write all");
    rd32(1, 8'h00, 32'h3, "R12 mirrored");
    wr32(1, 8'h00, 32'h2, "R12 only bit0 kept");
    rd32(1, 8'h00, 32'h0, "R12 cleared");

    // R13 unmapped accesses
    acc(0, 0, 1, 8'h30, 32'h0, 32'h0, 1, "R13 unlisted read");
    acc(0, 1, 1, 8'h08, 32'h0, 32'h0, 1, "R13 byte outside window");
    acc(1, 1, 1, 8'h08, 32'hFF, 32'h0, 1, "R13 byte write");
    rd32(1, 8'h08, 32'hFFFF_0003, "R13 byte write ignored");
    acc(1, 0, 1, 8'h42, 32'h1234_5678, 32'h0, 1, "R13 misaligned write");
    rd32(1, 8'h40, 32'hDDCC_BBAA, "R13 misaligned ignored");
    acc(1, 0, 1, 8'h34, 32'hFFFF_FFFF, 32'h0, 1, "R13 unlisted write");

    idle(3);
    checks++;
    if (q_data.size() != 0) begin
      fails++;
      $display("FAIL R14 responses missing got %0d pending expected 0", q_data.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule